// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory with a 512-byte nonvolatile array. A system clock oversamples the bus clock and data lines. The block finds start and stop conditions and decodes the addressing byte. It keeps one internal address counter. Writes go into a 16-byte page buffer. A stop that properly ends a write opens a self-timed busy window. When that window closes, the buffered bytes are copied into a synchronous RAM that stands in for the array.

A bus master uses it like any small serial memory. It can write a single byte or a burst into one page. It can read from the current counter, or load the counter with a dummy write and then read or stop. It can stream sequential reads across the whole array. While the write cycle runs, the device refuses its own address, so the master can poll it for completion. A protect input keeps the upper half of the array read-only.

Data is driven as an open-drain enable, where 1 pulls the line low. Drive changes are made only while the bus clock is low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The addressing byte is matched MSB first. Bits 7:4 must be 1010 and bits 3:2 must equal selPins[1:0]. Bit 1 is address bit 8 and bit 0 selects read (1) or write (0). A match is acknowledged by pulling the data line low during the 9th clock. A mismatch is not acknowledged, and the device then ignores the bus until the next start.
- R2: A byte write is the addressing byte, one word address byte and one data byte, each acknowledged, followed by a stop. It stores the byte at {bit 8, word address}.
- R3: During a write, only the low 4 counter bits advance after each data byte, wrapping within the same 16-byte page. Bytes beyond 16 overwrite earlier ones in order. After N bytes starting at offset k, the counter sits at offset (k+N) mod 16 of that page.
- R4: A read with no preceding word address returns the byte at the counter. Every byte sent advances the full 9-bit counter, which wraps from 1FFh to 000h.
- R5: With wpIn high, a data byte aimed at 100h–1FFh is not acknowledged and nothing is written. 000h–0FFh stays writable.
- R6: The array changes only when a stop follows at least one complete data byte and its acknowledge. A stop placed inside a data byte, or before any data byte, leaves the array untouched and starts no busy window.
- R7: After a committing stop, the device acknowledges no addressing byte until WR_CYCLES clocks plus the page copy have elapsed.
- R8: The addressing byte (write) and a word address followed by a stop load the counter without starting a write cycle. A later current-address read starts there.
- R9: During a read, a master acknowledge after a data byte makes the next byte follow. A master no-acknowledge releases the line, and nothing more is driven until a start or stop.
- R10: A dummy write of the word address, followed by a repeated start and a read addressing byte, returns the byte at that address.
- R11: After reset the data line is released.
- R12: The data drive enable never changes while the bus clock stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain enable; 1 pulls the data line low |
| selPins | input | 2 | Select strap compared with addressing byte bits 3:2 |
| wpIn | input | 1 | Write protect for the upper half of the array |

## Verification
A wrong counter does not stay hidden: it shows in the very next current-address read, or as a byte landing on the wrong page offset, one transaction later. A stale page mask or busy flag appears as a missing acknowledge on the next addressing byte, within nine bus clocks of the start. A state machine that mis-tracks a stop position shows up as a committed write that should have been dropped. Acknowledge polling then exposes it through an unexpected busy window.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int ADDR_W = 9;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef struct packed {
    logic loadAddr;     // word address accepted
    logic bufWrite;     // data byte acknowledged, store to page buffer
    logic incRead;      // data byte sent, step the counter
    logic startCommit;  // valid stop closing a write
  } dpCmd_t;
endpackage

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [7:0]        wrByte,
  output logic              addrMsb,
  output logic [7:0]        rdByte,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [ADDR_W-1:0]     addrQ;
  logic [7:0]            mem [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageMask;
  logic [BASE_W-1:0]     pageBase;
  logic [CNT_W-1:0]      waitCnt;
  logic                  walking;
  logic [PAGE_W-1:0]     walkIdx;

  // address counter: page-local step on write, full step on read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (cmd.loadAddr) begin
      addrQ <= wordAddr;
    end else if (cmd.bufWrite) begin
      addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + 1'b1;
    end else if (cmd.incRead) begin
      addrQ <= addrQ + 1'b1;
    end
  end

  // page buffer and its valid mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageMask <= '0;
    end else if (cmd.loadAddr) begin
      pageMask <= '0;
    end else if (cmd.bufWrite) begin
      pageMask[addrQ[PAGE_W-1:0]] <= 1'b1;
    end else if (walking && (&walkIdx)) begin
      pageMask <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.bufWrite) pageBuf[addrQ[PAGE_W-1:0]] <= wrByte;
  end

  // self-timed busy window followed by the page copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      walking  <= 1'b0;
      walkIdx  <= '0;
      pageBase <= '0;
    end else if (cmd.startCommit) begin
      waitCnt  <= CNT_W'(WR_CYCLES);
      pageBase <= addrQ[ADDR_W-1:PAGE_W];
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
      if (waitCnt == CNT_W'(1)) begin
        walking <= 1'b1;
        walkIdx <= '0;
      end
    end else if (walking) begin
      walkIdx <= walkIdx + 1'b1;
      if (&walkIdx) walking <= 1'b0;
    end
  end

  // array: one write port for the copy, one registered read port
  always_ff @(posedge clk) begin
    if (walking && pageMask[walkIdx]) mem[{pageBase, walkIdx}] <= pageBuf[walkIdx];
    rdByte <= mem[addrQ];
  end

  assign busy    = (waitCnt != '0) | walking;
  assign addrMsb = addrQ[ADDR_W-1];

  a_r3_page_local_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.bufWrite |=> (addrQ[ADDR_W-1:PAGE_W] == $past(addrQ[ADDR_W-1:PAGE_W])) &&
                     (addrQ[PAGE_W-1:0] == PAGE_W'($past(addrQ[PAGE_W-1:0]) + 1'b1)));
  a_r4_read_full_step: assert property (@(posedge clk) disable iff (!rstN)
    cmd.incRead |=> addrQ == ADDR_W'($past(addrQ) + 1'b1));
  a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startCommit |=> busy);
  a_r6_commit_has_data: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startCommit |-> pageMask != '0);
endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        selPins,
  input  logic              wpIn,
  input  logic              addrMsb,
  input  logic [7:0]        rdByte,
  input  logic              busy,
  output dpCmd_t            cmd,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [7:0]        wrByte,
  output logic              sdaOe
);
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADDR, S_WADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_WAIT
  } stateT;

  stateT       state;
  logic [1:0]  sclSy, sdaSy;
  logic        sclQ, sdaQ;
  logic        sclS, sdaS;
  logic        sclRise, sclFall, startDet, stopDet;
  logic [3:0]  bitCnt;
  logic [7:0]  rxSh;
  logic [6:0]  txSh;
  logic        isRead, addrHi, pend, mAck;
  logic        byteDone, protectHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= 2'b11;
      sdaSy <= 2'b11;
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
    end else begin
      sclSy <= {sclSy[0], sclIn};
      sdaSy <= {sdaSy[0], sdaIn};
      sclQ  <= sclSy[1];
      sdaQ  <= sdaSy[1];
    end
  end

  assign sclS     = sclSy[1];
  assign sdaS     = sdaSy[1];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign protectHit = wpIn & addrMsb;

  always_comb begin
    cmd.loadAddr    = (state == S_WADDR) && byteDone;
    cmd.bufWrite    = (state == S_WDATA_ACK) && sclFall;
    cmd.incRead     = (state == S_RDATA) && byteDone;
    cmd.startCommit = stopDet && (state == S_WDATA) && (bitCnt <= 4'd1) && pend;
  end

  assign wordAddr = {addrHi, rxSh};
  assign wrByte   = rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      rxSh   <= '0;
      txSh   <= '0;
      isRead <= 1'b0;
      addrHi <= 1'b0;
      pend   <= 1'b0;
      mAck   <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (startDet) begin
      state  <= S_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
      pend   <= 1'b0;
    end else if (stopDet) begin
      state <= S_IDLE;
      sdaOe <= 1'b0;
      pend  <= 1'b0;
    end else begin
      unique case (state)
        S_DEV, S_WADDR, S_WDATA: begin
          if (sclRise) begin
            rxSh   <= {rxSh[6:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCnt <= '0;
            if (state == S_DEV) begin
              if (rxSh[7:4] == DEV_ID && rxSh[3:2] == selPins && !busy) begin
                sdaOe  <= 1'b1;
                isRead <= rxSh[0];
                addrHi <= rxSh[1];
                state  <= S_DEV_ACK;
              end else begin
                state <= S_WAIT;
              end
            end else if (state == S_WADDR) begin
              sdaOe <= 1'b1;
              state <= S_WADDR_ACK;
            end else if (protectHit) begin
              state <= S_WAIT;
            end else begin
              sdaOe <= 1'b1;
              state <= S_WDATA_ACK;
            end
          end
        end
        S_DEV_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              txSh  <= rdByte[6:0];
              sdaOe <= ~rdByte[7];
              state <= S_RDATA;
            end else begin
              sdaOe <= 1'b0;
              state <= S_WADDR;
            end
          end
        end
        S_WADDR_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= S_WDATA;
          end
        end
        S_WDATA_ACK: begin
          if (sclFall) begin
            sdaOe  <= 1'b0;
            pend   <= 1'b1;
            bitCnt <= '0;
            state  <= S_WDATA;
          end
        end
        S_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            sdaOe <= 1'b0;
            state <= S_RACK;
          end else if (sclFall) begin
            sdaOe <= ~txSh[6];
            txSh  <= {txSh[5:0], 1'b0};
          end
        end
        S_RACK: begin
          if (sclRise) begin
            mAck <= ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              txSh   <= rdByte[6:0];
              sdaOe  <= ~rdByte[7];
              bitCnt <= '0;
              state  <= S_RDATA;
            end else begin
              state <= S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  a_r12_oe_quiet_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclQ && !startDet && !stopDet && !$past(startDet) && !$past(stopDet))
      |-> $stable(sdaOe));
  a_r7_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEV && byteDone && busy) |=> (state == S_WAIT && !sdaOe));
  a_r5_protect_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WDATA_ACK) |-> !(wpIn && addrMsb));
  a_r9_nack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK && sclFall && !mAck) |=> !sdaOe);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [1:0] selPins,
  input  logic       wpIn
);
  dpCmd_t            cmd;
  logic [ADDR_W-1:0] wordAddr;
  logic [7:0]        wrByte;
  logic [7:0]        rdByte;
  logic              addrMsb;
  logic              busy;

  eeprom_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selPins(selPins), .wpIn(wpIn), .addrMsb(addrMsb), .rdByte(rdByte),
    .busy(busy), .cmd(cmd), .wordAddr(wordAddr), .wrByte(wrByte), .sdaOe(sdaOe)
  );

  eeprom_dp #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wordAddr(wordAddr), .wrByte(wrByte),
    .addrMsb(addrMsb), .rdByte(rdByte), .busy(busy)
  );
endmodule

// File: tb/test_i2c_eeprom_slave.sv
module test_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WRC = 300;
  localparam logic [1:0] SEL = 2'b10;
  localparam int NVEC = 7;
  localparam logic [16:0] VEC [NVEC] = '{
    {9'h000, 8'h5A}, {9'h001, 8'h3C}, {9'h1FF, 8'hA5}, {9'h155, 8'h77},
    {9'h0AA, 8'h99}, {9'h100, 8'hE1}, {9'h07F, 8'hC3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic mSda = 1'b1;
  logic wpIn = 1'b0;
  logic [1:0] selPins = SEL;
  logic sdaOe;
  logic sdaIn;
  int nChecks = 0;
  int nFail = 0;
  int oeViol = 0;
  logic prevScl = 1'b1;
  logic prevOe = 1'b0;

  assign sdaIn = mSda & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_slave #(.WR_CYCLES(WRC)) i_i2c_eeprom_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .selPins(selPins), .wpIn(wpIn)
  );

  // R12 monitor: drive enable must hold while the bus clock stays high
  always @(negedge clk) begin
    if (rstN && sclIn && prevScl && (sdaOe !== prevOe)) oeViol++;
    prevScl <= sclIn;
    prevOe  <= sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q); sclIn = 1'b1; tick(Q); mSda = 1'b0; tick(Q); sclIn = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q); sclIn = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic writeBit(input logic b);
    mSda = b; tick(Q); sclIn = 1'b1; tick(2*Q); sclIn = 1'b0; tick(Q);
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; tick(Q); sclIn = 1'b1; tick(Q); b = sdaIn; tick(Q); sclIn = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = (b == 1'b0);
  endtask

  task automatic recvByte(output logic [7:0] v, input bit giveAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(!giveAck);
  endtask

  function automatic logic [7:0] slaveByte(input logic a8, input logic rd);
    return {4'b1010, SEL, a8, rd};
  endfunction

  task automatic waitReady(output int tries);
    bit ack;
    tries = 0;
    do begin
      busStart();
      sendByte(slaveByte(1'b0, 1'b0), ack);
      busStop();
      tries++;
    end while (!ack && tries < 200);
  endtask

  task automatic writeOne(input logic [8:0] a, input logic [7:0] d);
    bit ack;
    busStart();
    sendByte(slaveByte(a[8], 1'b0), ack);
    sendByte(a[7:0], ack);
    sendByte(d, ack);
    busStop();
  endtask

  task automatic randRead(input logic [8:0] a, output logic [7:0] d);
    bit ack;
    busStart();
    sendByte(slaveByte(a[8], 1'b0), ack);
    sendByte(a[7:0], ack);
    busStart();
    sendByte(slaveByte(1'b0, 1'b1), ack);
    recvByte(d, 1'b0);
    busStop();
  endtask

  task automatic curRead(output logic [7:0] d);
    bit ack;
    busStart();
    sendByte(slaveByte(1'b0, 1'b1), ack);
    recvByte(d, 1'b0);
    busStop();
  endtask

  task automatic pageWrite(input logic [8:0] base, input int off, input int n, input logic [7:0] v0);
    bit ack;
    int tries;
    busStart();
    sendByte(slaveByte(base[8], 1'b0), ack);
    sendByte({base[7:4], 4'(off)}, ack);
    for (int k = 0; k < n; k++) sendByte(8'(v0 + k), ack);
    busStop();
    waitReady(tries);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic b;
    bit ack;
    int tries;
    int zeros;

    tick(5);
    check(sdaOe == 1'b0, "R11 released in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(5);
    check(sdaOe == 1'b0, "R11 released after reset", sdaOe, 0);

    // R1: select mismatch and wrong identifier are not acknowledged
    busStart();
    sendByte({4'b1010, ~SEL, 2'b00}, ack);
    check(!ack, "R1 select mismatch nack", ack, 0);
    sendByte(8'h00, ack);
    check(!ack, "R1 ignored until start", ack, 0);
    busStop();
    busStart();
    sendByte({4'b1011, SEL, 2'b00}, ack);
    check(!ack, "R1 wrong id nack", ack, 0);
    busStop();
    busStart();
    sendByte(slaveByte(1'b0, 1'b0), ack);
    check(ack, "R1 match ack", ack, 1);
    busStop();

    // vector table: byte write, poll, random read back (R2, R7, R10)
    for (int i = 0; i < NVEC; i++) begin
      writeOne(VEC[i][16:8], VEC[i][7:0]);
      waitReady(tries);
      check(tries > 1, "R7 busy after commit", tries, 2);
      randRead(VEC[i][16:8], d);
      check(d == VEC[i][7:0], "R2 R10 read back", d, VEC[i][7:0]);
    end

    // R4: sequential read wraps 1FF -> 000, then counter at 001
    busStart();
    sendByte(slaveByte(1'b1, 1'b0), ack);
    sendByte(8'hFF, ack);
    busStart();
    sendByte(slaveByte(1'b0, 1'b1), ack);
    recvByte(d, 1'b1);
    recvByte(d2, 1'b0);
    busStop();
    check(d == 8'hA5, "R4 first byte at 1FF", d, 8'hA5);
    check(d2 == 8'h5A, "R4 wrap to 000 (R9 ack continues)", d2, 8'h5A);
    curRead(d);
    check(d == 8'h3C, "R4 current read at 001", d, 8'h3C);

    // R9: after a no-acknowledge the device drives nothing
    busStart();
    sendByte(slaveByte(1'b0, 1'b1), ack);
    recvByte(d, 1'b0);
    zeros = 0;
    for (int i = 0; i < 8; i++) begin
      readBit(b);
      if (b == 1'b0) zeros++;
    end
    busStop();
    check(zeros == 0, "R9 released after nack", zeros, 0);

    // R5: protected upper half
    wpIn = 1'b1;
    busStart();
    sendByte(slaveByte(1'b1, 1'b0), ack);
    sendByte(8'h55, ack);
    sendByte(8'h00, ack);
    check(!ack, "R5 protected data nack", ack, 0);
    busStop();
    waitReady(tries);
    check(tries == 1, "R5 no busy window", tries, 1);
    randRead(9'h155, d);
    check(d == 8'h77, "R5 upper half unchanged", d, 8'h77);
    writeOne(9'h0AA, 8'h66);
    waitReady(tries);
    randRead(9'h0AA, d);
    check(d == 8'h66, "R5 lower half writable", d, 8'h66);
    wpIn = 1'b0;

    // R6: stop inside a data byte aborts
    busStart();
    sendByte(slaveByte(1'b1, 1'b0), ack);
    sendByte(8'h00, ack);
    writeBit(1'b0); writeBit(1'b0); writeBit(1'b0);
    busStop();
    waitReady(tries);
    check(tries == 1, "R6 mid-byte stop no busy", tries, 1);
    randRead(9'h100, d);
    check(d == 8'hE1, "R6 array unchanged", d, 8'hE1);

    // R8: set address only
    busStart();
    sendByte(slaveByte(1'b0, 1'b0), ack);
    sendByte(8'hAA, ack);
    busStop();
    waitReady(tries);
    check(tries == 1, "R8 R6 no write cycle", tries, 1);
    curRead(d);
    check(d == 8'h66, "R8 counter loaded", d, 8'h66);

    // R3: page wrap and counter position
    pageWrite(9'h020, 0, 16, 8'h40);
    pageWrite(9'h020, 10, 13, 8'h80);
    curRead(d);
    check(d == 8'h47, "R3 counter at offset 7", d, 8'h47);
    randRead(9'h023, d);
    check(d == 8'h89, "R3 wrapped byte at offset 3", d, 8'h89);
    randRead(9'h02F, d);
    check(d == 8'h85, "R3 byte at offset 15", d, 8'h85);
    pageWrite(9'h130, 0, 18, 8'h10);
    randRead(9'h130, d);
    check(d == 8'h20, "R3 overwrite offset 0", d, 8'h20);
    randRead(9'h131, d);
    check(d == 8'h21, "R3 overwrite offset 1", d, 8'h21);
    randRead(9'h132, d);
    check(d == 8'h12, "R3 offset 2 kept", d, 8'h12);

    check(oeViol == 0, "R12 drive stable while clock high", oeViol, 0);
    summary();
    $finish;
  end
endmodule